// File: doc/BRIEF.md
# Event Trigger Flag and Interrupt Gate

This block sits at the end of a pulse-generator event chain. It takes three single-cycle event strobes: one for an interrupt and two for analog conversion starts (channels A and B). For each it drives a registered one-cycle output pulse and keeps a sticky status flag that software can read back and clear.

The two conversion channels pulse on every event, whatever their flags hold, so a converter is never starved. The interrupt channel is gated. Once its flag is set, no further interrupt leaves the block until software clears that flag. During that time a single later event is remembered in a one-deep pending slot and is released right after the clear. Any event beyond that one is dropped.

Software reads the flags through a 16-bit read-only word. It clears them through a separate write-one-to-clear port, qualified by a write strobe. The asynchronous active-low reset is released through an internal two-stage synchronizer.

Top module: `evtrig_flag_gate`

## Requirements
- R1: The readback word is REG_W (16) bits. Bit 0 is the interrupt flag, bit 2 is the conversion-A flag and bit 3 is the conversion-B flag. Bit 1 and bits 15 to 4 always read 0.
- R2: While reset is held, and after it is released, all flags, all three output pulses and the pending slot are 0.
- R3: Each conversion event gives a high on its output on the next cycle only, even when its flag is already set. Events on consecutive cycles give a pulse on each cycle.
- R4: A conversion event sets its flag on the next cycle. A write with bit 2 (channel A) or bit 3 (channel B) set clears that flag. An event and a clear on the same flag in the same cycle leave the flag set.
- R5: An interrupt event while the interrupt flag is 0 drives the interrupt output high for the next cycle only and sets the flag. A clear of bit 0 in that same cycle has no effect.
- R6: While the interrupt flag is set, the interrupt output stays low unless a clear of bit 0 releases a pending event.
- R7: While the interrupt flag is set, the first interrupt event is held as pending. Further events are discarded until the pending one is released.
- R8: A clear of bit 0 with an event pending, and no new event in that cycle, gives one interrupt pulse on the next cycle. The flag stays at 1 and the pending slot empties. With nothing pending, the same clear returns the flag to 0 with no pulse.
- R9: An interrupt event and a clear of bit 0 in the same cycle, while the flag is set, leave the flag set, fill the pending slot and give no pulse.
- R10: Clear bits other than 0, 2 and 3 have no effect. Clear data has no effect at all when the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_evt_i | input | 1 | Interrupt event strobe |
| soca_evt_i | input | 1 | Conversion-A event strobe |
| socb_evt_i | input | 1 | Conversion-B event strobe |
| clr_wr_i | input | 1 | Write strobe for the clear port |
| clr_data_i | input | REG_W | Write-one-to-clear mask, same bit layout as the readback |
| flags_o | output | REG_W | Flag readback word |
| irq_o | output | 1 | Registered interrupt pulse |
| soca_o | output | 1 | Registered conversion-A pulse |
| socb_o | output | 1 | Conversion-B pulse |

## Verification
The bench builds the block with its default REG_W of 16. At that width every combination of the three event strobes can be swept together with every pattern of the write strobe, the three flag clear bits and a reserved clear bit. The sweep runs twice in two different orders, so each input combination meets a variety of flag and pending states. Directed sequences then walk through the pending fill, the discard of extra events, the release on clear, the clash of an event with a clear on the same flag, and the handling of reserved clear bits.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;
  // Bit positions inside the readback and clear words; software decodes these.
  localparam int unsigned IRQ_BIT  = 0;
  localparam int unsigned SOCA_BIT = 2;
  localparam int unsigned SOCB_BIT = 3;
  // Number of ungated conversion channels, placed at consecutive bits from SOCA_BIT.
  localparam int unsigned NUM_SOC  = 2;
  // Minimum width of the register word that holds all defined bits.
  localparam int unsigned MIN_W    = SOCA_BIT + NUM_SOC;

  function automatic int unsigned soc_bit(input int unsigned idx);
    return SOCA_BIT + idx;
  endfunction
endpackage

// File: rtl/evtrig_rst_sync.sv
module evtrig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/evtrig_soc_path.sv
module evtrig_soc_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic flag_o
);
  logic pulse_q, pulse_d;
  logic flag_q, flag_d;
  logic flag_en;

  // Pulse is never gated by the flag; an event always beats a clear.
  always_comb begin
    pulse_d = evt_i;
    flag_en = evt_i | clr_i;
    flag_d  = evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= pulse_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign pulse_o = pulse_q;
  assign flag_o  = flag_q;

  a_r3_pulse_follows_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> pulse_o);
  a_r3_no_spurious_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> !pulse_o);
  a_r4_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o);
  a_r4_clear_drops_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !flag_o);
endmodule

// File: rtl/evtrig_irq_gate.sv
module evtrig_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic irq_o,
  output logic flag_o,
  output logic pend_o
);
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,  // flag clear, nothing held
    ST_FLAG  = 2'b01,  // flag set, slot empty
    ST_PEND  = 2'b11   // flag set, one event held
  } gate_st_e;

  gate_st_e st_q, st_d;
  logic     irq_q, irq_d;

  always_comb begin
    st_d  = st_q;
    irq_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (evt_i) begin
          irq_d = 1'b1;
          st_d  = ST_FLAG;
        end
      end
      ST_FLAG: begin
        if (evt_i)      st_d = ST_PEND;   // event wins over a same-cycle clear
        else if (clr_i) st_d = ST_IDLE;
      end
      ST_PEND: begin
        if (!evt_i && clr_i) begin
          irq_d = 1'b1;                   // release held event, flag set again
          st_d  = ST_FLAG;
        end
        // extra events are dropped; event + clear keeps the slot full
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o  = irq_q;
  assign flag_o = st_q[0];
  assign pend_o = st_q[1];

  a_r7_pend_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> flag_o);
  a_r5_pulse_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
  a_r5_first_event_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && evt_i) |=> (irq_o && flag_o));
  a_r6_silent_while_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> !irq_o);
  a_r8_release_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && clr_i && !evt_i) |=> (irq_o && flag_o && !pend_o));
  a_r9_event_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && clr_i && evt_i) |=> (!irq_o && pend_o));
  a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/evtrig_flag_regs.sv
module evtrig_flag_regs
  import evtrig_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_wr_i,
  input  logic [REG_W-1:0]    clr_data_i,
  input  logic                irq_flag_i,
  input  logic [NUM_SOC-1:0]  soc_flag_i,
  output logic                irq_clr_o,
  output logic [NUM_SOC-1:0]  soc_clr_o,
  output logic [REG_W-1:0]    flags_o
);
  localparam logic [REG_W-1:0] DEF_MASK =
    (REG_W'(1) << IRQ_BIT) | (REG_W'((1 << NUM_SOC) - 1) << SOCA_BIT);

  logic [REG_W-1:0] word;

  always_comb begin
    irq_clr_o = clr_wr_i & clr_data_i[IRQ_BIT];
  end

  for (genvar k = 0; k < NUM_SOC; k++) begin : g_soc_clr
    assign soc_clr_o[k] = clr_wr_i & clr_data_i[soc_bit(k)];
  end

  always_comb begin
    word          = '0;
    word[IRQ_BIT] = irq_flag_i;
    for (int k = 0; k < NUM_SOC; k++) begin
      word[soc_bit(k)] = soc_flag_i[k];
    end
  end

  assign flags_o = word;

  a_r1_reserved_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & ~DEF_MASK) == '0);
  a_r10_no_write_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr_i |-> (irq_clr_o == 1'b0 && soc_clr_o == '0));
endmodule

// File: rtl/evtrig_flag_gate.sv
module evtrig_flag_gate
  import evtrig_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_evt_i,
  input  logic             soca_evt_i,
  input  logic             socb_evt_i,
  input  logic             clr_wr_i,
  input  logic [REG_W-1:0] clr_data_i,
  output logic [REG_W-1:0] flags_o,
  output logic             irq_o,
  output logic             soca_o,
  output logic             socb_o
);
  logic               rst_n;
  logic [NUM_SOC-1:0] soc_evt, soc_clr, soc_flag, soc_pulse;
  logic               irq_clr, irq_flag, irq_pend;

  initial begin
    if (REG_W < MIN_W) $error("REG_W too small for flag layout");
  end

  evtrig_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  assign soc_evt = {socb_evt_i, soca_evt_i};

  for (genvar k = 0; k < NUM_SOC; k++) begin : g_soc
    evtrig_soc_path u_path (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .evt_i   (soc_evt[k]),
      .clr_i   (soc_clr[k]),
      .pulse_o (soc_pulse[k]),
      .flag_o  (soc_flag[k])
    );
  end

  evtrig_irq_gate u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .evt_i  (irq_evt_i),
    .clr_i  (irq_clr),
    .irq_o  (irq_o),
    .flag_o (irq_flag),
    .pend_o (irq_pend)
  );

  evtrig_flag_regs #(.REG_W(REG_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .clr_wr_i   (clr_wr_i),
    .clr_data_i (clr_data_i),
    .irq_flag_i (irq_flag),
    .soc_flag_i (soc_flag),
    .irq_clr_o  (irq_clr),
    .soc_clr_o  (soc_clr),
    .flags_o    (flags_o)
  );

  assign soca_o = soc_pulse[0];
  assign socb_o = soc_pulse[1];

  a_r2_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_n |-> (flags_o == '0 && !irq_o && !soca_o && !socb_o && !irq_pend));
endmodule

// File: tb/sim_evtrig_flag_gate.sv
module sim_evtrig_flag_gate;
  localparam int unsigned W      = 16;
  localparam time         TCLK   = 10ns;
  localparam int          WD_MAX = 100000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ei, ea, eb, wr;
  logic [W-1:0] cd;
  logic [W-1:0] flags;
  logic         irq, soca, socb;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Bench model state
  logic m_fi, m_pend, m_fa, m_fb, m_irq, m_pa, m_pb;

  always #(TCLK/2) clk = ~clk;

  evtrig_flag_gate #(.REG_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_evt_i(ei), .soca_evt_i(ea),
    .socb_evt_i(eb), .clr_wr_i(wr), .clr_data_i(cd), .flags_o(flags),
    .irq_o(irq), .soca_o(soca), .socb_o(socb)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_word();
    logic [W-1:0] w = '0;
    w[0] = m_fi; w[2] = m_fa; w[3] = m_fb;
    return w;
  endfunction

  // Called at a negedge: apply inputs, advance model, compare at next negedge.
  task automatic step(input logic e_i, input logic e_a, input logic e_b,
                      input logic w, input logic [W-1:0] d,
                      input string tag_irq, input string tag_reg);
    logic ci, ca, cb;
    ei = e_i; ea = e_a; eb = e_b; wr = w; cd = d;
    ci = w & d[0]; ca = w & d[2]; cb = w & d[3];
    m_pa = e_a; m_pb = e_b;
    m_fa = e_a | (m_fa & ~ca);
    m_fb = e_b | (m_fb & ~cb);
    if (!m_fi) begin
      m_irq = e_i; m_fi = e_i; m_pend = 1'b0;
    end else if (e_i) begin
      m_irq = 1'b0; m_pend = 1'b1;
    end else if (ci) begin
      if (m_pend) begin m_irq = 1'b1; m_pend = 1'b0; end
      else begin m_irq = 1'b0; m_fi = 1'b0; end
    end else begin
      m_irq = 1'b0;
    end
    @(negedge clk);
    chk("R3", W'(soca), W'(m_pa));
    chk("R3", W'(socb), W'(m_pb));
    chk(tag_irq, W'(irq), W'(m_irq));
    chk(tag_reg, flags, exp_word());
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, '0, tag, tag);
  endtask

  // Sweep code: bits [2:0] events, [3] write strobe, [4] clr0, [5] clr2, [6] clr3, [7] clr1, [8] clr7
  task automatic apply_code(input int c);
    logic [W-1:0] d = '0;
    d[0] = c[4]; d[2] = c[5]; d[3] = c[6]; d[1] = c[7]; d[7] = c[8];
    step(c[0], c[1], c[2], c[3], d, "R5", "R1");
  endtask

  initial begin
    for (int i = 0; i < WD_MAX; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ei = 0; ea = 0; eb = 0; wr = 0; cd = '0;
    m_fi = 0; m_pend = 0; m_fa = 0; m_fb = 0; m_irq = 0; m_pa = 0; m_pb = 0;
    repeat (3) @(negedge clk);
    // R2: reset state while held, even with events applied
    ei = 1; ea = 1; eb = 1;
    @(negedge clk);
    chk("R2", flags, '0);
    chk("R2", {irq, soca, socb}, '0);
    ei = 0; ea = 0; eb = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", flags, '0);
    chk("R2", {irq, soca, socb}, '0);

    // R5 / R6 / R7 / R8: pending fill, discard, release
    step(1, 0, 0, 0, '0, "R5", "R5");          // fires, flag set
    step(1, 0, 0, 0, '0, "R6", "R7");          // held as pending
    step(1, 0, 0, 0, '0, "R7", "R7");          // discarded
    step(1, 0, 0, 0, '0, "R7", "R7");          // discarded
    idle("R6");
    step(0, 0, 0, 1, 16'h0001, "R8", "R8");    // release pending: pulse, flag stays
    idle("R8");
    step(0, 0, 0, 1, 16'h0001, "R8", "R8");    // nothing pending: flag drops, no pulse
    idle("R8");

    // R5: event with same-cycle clear while flag is clear
    step(1, 0, 0, 1, 16'h0001, "R5", "R5");
    // R9: event + clear while flag set -> flag stays, pending filled
    step(1, 0, 0, 1, 16'h0001, "R9", "R9");
    step(0, 0, 0, 1, 16'h0001, "R9", "R9");    // releases the held event
    step(0, 0, 0, 1, 16'h0001, "R8", "R8");    // flag returns to 0

    // R3 / R4: conversion pulses regardless of flag, back to back
    step(0, 1, 1, 0, '0, "R3", "R4");
    step(0, 1, 1, 0, '0, "R3", "R4");
    step(0, 1, 0, 0, '0, "R3", "R4");
    step(0, 0, 1, 1, 16'h0008, "R4", "R4");    // B event beats B clear
    step(0, 0, 0, 1, 16'h0004, "R4", "R4");    // clear A only
    step(1, 0, 0, 0, '0, "R5", "R5");

    // R10: reserved clear bits and no write strobe
    step(0, 0, 0, 1, 16'hFFF2, "R10", "R10");
    step(0, 0, 0, 0, 16'hFFFF, "R10", "R10");
    step(0, 0, 0, 1, 16'h000D, "R10", "R10");
    idle("R1");

    // Exhaustive sweep, two orders
    for (int i = 0; i < 512; i++) apply_code(i);
    for (int i = 0; i < 512; i++) apply_code((i * 89 + 17) % 512);
    step(0, 0, 0, 1, 16'h000D, "R8", "R4");
    step(0, 0, 0, 1, 16'h000D, "R8", "R4");
    idle("R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule